// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox with Status Flags

This block passes bytes between a host computer bus and a sound coprocessor. The host posts a command byte and trades data bytes with the coprocessor through one inbound and one outbound data register. Two status flags track the traffic. The command flag sits in bit 0 and is raised by a host command write. The data flag sits in bit 7 and is shared by both directions: it is raised whenever either side deposits a data byte and dropped whenever either side takes one. The host sees both flags through its status read. The coprocessor sees them through its own raw status port. It lowers the command flag through a dedicated acknowledge port.

The coprocessor also holds a memory page register and a channel-0 volume register. Two special ports copy a bit of those registers into the flags. This lets firmware force a flag to a known value. A host control port issues single-cycle coprocessor reset and NMI request pulses and drives an LED.

Both sides use synchronous single-cycle read and write strobes sampled on the rising clock edge. Read data is combinational from the address during the strobe cycle. Register and flag updates take effect at the edge that ends the strobe.

Top module: `snd_mailbox`

## Requirements
- R1: After reset both flags are 0, the LED and both request pulses are 0, and a host status read returns 0x7E.
- R2: A host write to address 0xBB stores the byte as the command and sets status bit 0; a coprocessor read of port 0x01 returns that command.
- R3: A host write to address 0xB3 stores the byte for the coprocessor and sets status bit 7; a coprocessor read of port 0x02 returns it and clears bit 7.
- R4: A coprocessor write to port 0x03 stores a reply and sets bit 7; a host read of 0xB3 returns the reply and clears bit 7.
- R5: A host read of 0xBB returns the raw status OR 0x7E; a coprocessor read of port 0x04 returns the raw status, with only bits 7 and 0 ever set.
- R6: Any coprocessor read or write of port 0x05 clears bit 0, and the read returns 0xFF.
- R7: Any coprocessor access to port 0x0A loads bit 7 from bit 0 of the page register, which is written through port 0x00; the read returns 0xFF.
- R8: Any coprocessor access to port 0x0B loads bit 0 from bit 5 of the channel-0 volume register, which is written through port 0x06; the read returns 0xFF.
- R9: A host write to 0x33 with bit 7 set gives a one-cycle coprocessor reset pulse, and with bit 6 set a one-cycle NMI pulse. Each pulse is high during the cycle after the write.
- R10: Bit 5 of a host write to 0x33 sets the LED. The LED keeps that value until the next write to 0x33.
- R11: A set and a clear of the same flag in the same cycle, from either side, leave the flag set.
- R12: Reads of unmapped addresses on either side return 0xFF. Writes to unmapped addresses leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host port address, low byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| cop_addr | input | 8 | Coprocessor port address |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data |
| cop_reset_req | output | 1 | One-cycle coprocessor reset request |
| cop_nmi_req | output | 1 | One-cycle NMI request |
| led | output | 1 | LED drive |

## Verification
The hardest case to reach is a set and a clear of the same flag landing on the same edge, because normal traffic from one side never produces it. The bench drives both strobe sets in the same clock cycle. It pairs a host command write with a coprocessor acknowledge. It pairs a host data read with a coprocessor reply write, and a host data write with a coprocessor data read. In each case it then reads the raw status. The flag-load ports are reached by first writing the page and volume registers to chosen values. Each load is then checked in both polarities.

// File: rtl/snd_mailbox_pkg.sv
// Shared constants for the mailbox: port addresses on both sides and
// the positions of the two status flags.
package snd_mailbox_pkg;
    localparam int MBX_DW = 8;
    localparam int MBX_AW = 8;

    // host side addresses (low address byte)
    localparam logic [MBX_AW-1:0] H_STAT_CMD = 8'hBB;
    localparam logic [MBX_AW-1:0] H_DATA     = 8'hB3;
    localparam logic [MBX_AW-1:0] H_CTRL     = 8'h33;

    // coprocessor side ports
    localparam logic [MBX_AW-1:0] C_PAGE     = 8'h00;
    localparam logic [MBX_AW-1:0] C_CMD      = 8'h01;
    localparam logic [MBX_AW-1:0] C_HDATA    = 8'h02;
    localparam logic [MBX_AW-1:0] C_REPLY    = 8'h03;
    localparam logic [MBX_AW-1:0] C_STAT     = 8'h04;
    localparam logic [MBX_AW-1:0] C_ACK      = 8'h05;
    localparam logic [MBX_AW-1:0] C_VOL0     = 8'h06;
    localparam logic [MBX_AW-1:0] C_LD_DATA  = 8'h0A;
    localparam logic [MBX_AW-1:0] C_LD_CMD   = 8'h0B;

    // flag indices inside the flag array
    localparam int FLAG_CMD  = 0;
    localparam int FLAG_DATA = 1;
    localparam int NFLAGS    = 2;

    // control byte bit positions
    localparam int CTL_RST_BIT = 7;
    localparam int CTL_NMI_BIT = 6;
    localparam int CTL_LED_BIT = 5;

    // volume register keeps six bits; bit 5 feeds the command flag load
    localparam int VOL_W       = 6;
    localparam int VOL_SRC_BIT = 5;
endpackage

// File: rtl/mbx_flag_cell.sv
// One status flag with set, clear and load requests.
// Priority: set over load over clear. Assumes requests are single-cycle
// strobes sampled on the rising edge; synchronous active-low reset to 0.
module mbx_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ld_i,
    input  logic ld_val_i,
    output logic q_o
);
    // flag register update with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= 1'b0;
        else if (set_i)   q_o <= 1'b1;
        else if (ld_i)    q_o <= ld_val_i;
        else if (clr_i)   q_o <= 1'b0;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !ld_i) |=> !q_o);
    // R7
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !set_i) |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/mbx_status.sv
// Status register built from the command and data flags.
// Merges the set/clear requests of both sides per flag and presents
// the raw status byte (flags in bit 0 and the top bit, others zero).
module mbx_status
    import snd_mailbox_pkg::*;
#(
    parameter int DW = MBX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NFLAGS-1:0] h_set_i,
    input  logic [NFLAGS-1:0] h_clr_i,
    input  logic [NFLAGS-1:0] c_set_i,
    input  logic [NFLAGS-1:0] c_clr_i,
    input  logic [NFLAGS-1:0] c_ld_i,
    input  logic [NFLAGS-1:0] c_ld_val_i,
    output logic [DW-1:0] raw_o
);
    localparam int DATA_POS = DW - 1;
    localparam int CMD_POS  = 0;

    logic [NFLAGS-1:0] flag_q;

    // one flag cell per status flag
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        mbx_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (h_set_i[g] | c_set_i[g]),
            .clr_i    (h_clr_i[g] | c_clr_i[g]),
            .ld_i     (c_ld_i[g]),
            .ld_val_i (c_ld_val_i[g]),
            .q_o      (flag_q[g])
        );
    end

    // place the flags into the status byte
    always_comb begin
        raw_o           = '0;
        raw_o[CMD_POS]  = flag_q[FLAG_CMD];
        raw_o[DATA_POS] = flag_q[FLAG_DATA];
    end
endmodule

// File: rtl/mbx_host_port.sv
// Host-side decoder: command and inbound data registers, the control
// port (reset/NMI pulses, LED) and the host read multiplexer.
// Assumes one strobe at a time on this side; reads are combinational.
module mbx_host_port
    import snd_mailbox_pkg::*;
#(
    parameter int DW = MBX_DW,
    parameter int AW = MBX_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] reply_i,
    output logic [DW-1:0] cmd_o,
    output logic [DW-1:0] hdata_o,
    output logic [NFLAGS-1:0] set_o,
    output logic [NFLAGS-1:0] clr_o,
    output logic          rst_req_o,
    output logic          nmi_req_o,
    output logic          led_o
);
    localparam logic [DW-1:0] STAT_FILL = ~(DW'(1) | (DW'(1) << (DW - 1)));

    logic cmd_wr, data_wr, data_rd, ctl_wr;

    // address decode of host strobes
    always_comb begin
        cmd_wr  = wr_i && (addr_i == H_STAT_CMD);
        data_wr = wr_i && (addr_i == H_DATA);
        data_rd = rd_i && (addr_i == H_DATA);
        ctl_wr  = wr_i && (addr_i == H_CTRL);
    end

    // flag requests towards the status unit
    always_comb begin
        set_o            = '0;
        clr_o            = '0;
        set_o[FLAG_CMD]  = cmd_wr;
        set_o[FLAG_DATA] = data_wr;
        clr_o[FLAG_DATA] = data_rd;
    end

    // command and inbound data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o   <= '0;
            hdata_o <= '0;
        end else begin
            if (cmd_wr)  cmd_o   <= wdata_i;
            if (data_wr) hdata_o <= wdata_i;
        end
    end

    // control port: single-cycle requests and LED latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
            led_o     <= 1'b0;
        end else begin
            rst_req_o <= ctl_wr && wdata_i[CTL_RST_BIT];
            nmi_req_o <= ctl_wr && wdata_i[CTL_NMI_BIT];
            if (ctl_wr) led_o <= wdata_i[CTL_LED_BIT];
        end
    end

    // host read multiplexer
    always_comb begin
        rdata_o = '1;
        if (rd_i) begin
            case (addr_i)
                H_STAT_CMD: rdata_o = status_i | STAT_FILL;
                H_DATA:     rdata_o = reply_i;
                default:    rdata_o = '1;
            endcase
        end
    end

    // R9
    rst_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata_i[CTL_RST_BIT]) |=> (rst_req_o && !$past(rst_req_o) || rst_req_o));
    // R9
    nmi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> !nmi_req_o);
    // R10
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(led_o));
endmodule

// File: rtl/mbx_cop_port.sv
// Coprocessor-side decoder: reply register, page and channel-0 volume
// registers, flag requests (including the two flag-load ports) and the
// coprocessor read multiplexer. Any access means a read or a write strobe.
module mbx_cop_port
    import snd_mailbox_pkg::*;
#(
    parameter int DW = MBX_DW,
    parameter int AW = MBX_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] cmd_i,
    input  logic [DW-1:0] hdata_i,
    output logic [DW-1:0] reply_o,
    output logic [NFLAGS-1:0] set_o,
    output logic [NFLAGS-1:0] clr_o,
    output logic [NFLAGS-1:0] ld_o,
    output logic [NFLAGS-1:0] ld_val_o
);
    logic          acc;
    logic [DW-1:0] page_q;
    logic [VOL_W-1:0] vol0_q;

    assign acc = wr_i | rd_i;

    // page, volume and reply registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            vol0_q  <= '0;
            reply_o <= '0;
        end else if (wr_i) begin
            case (addr_i)
                C_PAGE:  page_q  <= wdata_i;
                C_VOL0:  vol0_q  <= wdata_i[VOL_W-1:0];
                C_REPLY: reply_o <= wdata_i;
                default: ;
            endcase
        end
    end

    // flag requests from this side
    always_comb begin
        set_o               = '0;
        clr_o               = '0;
        ld_o                = '0;
        ld_val_o            = '0;
        set_o[FLAG_DATA]    = wr_i && (addr_i == C_REPLY);
        clr_o[FLAG_DATA]    = rd_i && (addr_i == C_HDATA);
        clr_o[FLAG_CMD]     = acc  && (addr_i == C_ACK);
        ld_o[FLAG_DATA]     = acc  && (addr_i == C_LD_DATA);
        ld_val_o[FLAG_DATA] = page_q[0];
        ld_o[FLAG_CMD]      = acc  && (addr_i == C_LD_CMD);
        ld_val_o[FLAG_CMD]  = vol0_q[VOL_SRC_BIT];
    end

    // coprocessor read multiplexer
    always_comb begin
        rdata_o = '1;
        if (rd_i) begin
            case (addr_i)
                C_CMD:   rdata_o = cmd_i;
                C_HDATA: rdata_o = hdata_i;
                C_STAT:  rdata_o = status_i;
                default: rdata_o = '1;
            endcase
        end
    end

    // R8
    vol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == C_VOL0) |=> (ld_val_o[FLAG_CMD] == $past(wdata_i[VOL_SRC_BIT])));
endmodule

// File: rtl/snd_mailbox.sv
// Top of the host/coprocessor mailbox. Wires the host decoder, the
// coprocessor decoder and the shared status unit together. Both sides
// run on one clock; synchronous active-low reset.
module snd_mailbox
    import snd_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] cop_addr,
    input  logic       cop_wr,
    input  logic       cop_rd,
    input  logic [7:0] cop_wdata,
    output logic [7:0] cop_rdata,
    output logic       cop_reset_req,
    output logic       cop_nmi_req,
    output logic       led
);
    logic [MBX_DW-1:0] status, cmd, hdata, reply;
    logic [NFLAGS-1:0] h_set, h_clr, c_set, c_clr, c_ld, c_ld_val;

    mbx_host_port #(.DW(MBX_DW), .AW(MBX_AW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (host_addr),
        .wr_i      (host_wr),
        .rd_i      (host_rd),
        .wdata_i   (host_wdata),
        .rdata_o   (host_rdata),
        .status_i  (status),
        .reply_i   (reply),
        .cmd_o     (cmd),
        .hdata_o   (hdata),
        .set_o     (h_set),
        .clr_o     (h_clr),
        .rst_req_o (cop_reset_req),
        .nmi_req_o (cop_nmi_req),
        .led_o     (led)
    );

    mbx_cop_port #(.DW(MBX_DW), .AW(MBX_AW)) u_cop (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (cop_addr),
        .wr_i     (cop_wr),
        .rd_i     (cop_rd),
        .wdata_i  (cop_wdata),
        .rdata_o  (cop_rdata),
        .status_i (status),
        .cmd_i    (cmd),
        .hdata_i  (hdata),
        .reply_o  (reply),
        .set_o    (c_set),
        .clr_o    (c_clr),
        .ld_o     (c_ld),
        .ld_val_o (c_ld_val)
    );

    mbx_status #(.DW(MBX_DW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_set_i    (h_set),
        .h_clr_i    (h_clr),
        .c_set_i    (c_set),
        .c_clr_i    (c_clr),
        .c_ld_i     (c_ld),
        .c_ld_val_i (c_ld_val),
        .raw_o      (status)
    );

    // R2
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == H_STAT_CMD) |=> status[0]);
    // R5
    stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:1] == 6'b0);
endmodule

// File: tb/test_snd_mailbox.sv
module test_snd_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0, cop_addr = '0, cop_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0, cop_wr = 1'b0, cop_rd = 1'b0;
    logic [7:0] host_rdata, cop_rdata;
    logic       cop_reset_req, cop_nmi_req, led;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snd_mailbox i_snd_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_rd(cop_rd),
        .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
        .cop_reset_req(cop_reset_req), .cop_nmi_req(cop_nmi_req), .led(led)
    );

    // vector: [31:28] requirement, [27:24] kind (0 host wr, 1 host rd,
    // 2 cop wr, 3 cop rd), [23:16] address, [15:8] write data, [7:0] expected read
    localparam int NV = 36;
    localparam logic [31:0] VEC [NV] = '{
        32'h11BB007E, // R1 reset status
        32'h20BB5A00, // R2 command write
        32'h51BB007F, // R5 host status view
        32'h2301005A, // R2 command read
        32'h53040001, // R5 raw status
        32'h630500FF, // R6 ack read returns FF
        32'h63040000, // R6 command flag cleared
        32'h30B3C300, // R3 host data write
        32'h33040080, // R3 data flag set
        32'h330200C3, // R3 data read
        32'h33040000, // R3 data flag cleared
        32'h42033C00, // R4 reply write
        32'h41BB00FE, // R4 host sees data flag
        32'h41B3003C, // R4 host reads reply
        32'h41BB007E, // R4 data flag cleared
        32'h60BB1100, // R6 command again
        32'h62050000, // R6 ack by write
        32'h63040000, // R6 cleared
        32'h72000100, // R7 page = 1
        32'h720A0000, // R7 load data flag
        32'h73040080, // R7 loaded 1
        32'h7200FE00, // R7 page bit0 = 0
        32'h730A00FF, // R7 load by read, returns FF
        32'h73040000, // R7 loaded 0
        32'h82062000, // R8 volume bit5 = 1
        32'h830B00FF, // R8 load by read
        32'h83040001, // R8 loaded 1
        32'h8206DF00, // R8 volume bit5 = 0
        32'h820B0000, // R8 load by write
        32'h83040000, // R8 loaded 0
        32'hC14200FF, // R12 unmapped host read
        32'hC32F00FF, // R12 unmapped cop read
        32'hC044FF00, // R12 unmapped host write
        32'hC277FF00, // R12 unmapped cop write
        32'hC3040000, // R12 flags untouched
        32'hC1BB007E  // R12 host status untouched
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d got=%h exp=%h", req, got, exp);
        end
    endtask

    // one access on one side; read data sampled mid-strobe before the edge
    task automatic do_op(input int kind, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
        @(negedge clk);
        if (kind < 2) begin
            host_addr = a; host_wdata = d;
            host_wr = (kind == 0); host_rd = (kind == 1);
        end else begin
            cop_addr = a; cop_wdata = d;
            cop_wr = (kind == 2); cop_rd = (kind == 3);
        end
        #1 rd = (kind < 2) ? host_rdata : cop_rdata;
        @(negedge clk);
        host_wr = 0; host_rd = 0; cop_wr = 0; cop_rd = 0;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 outputs after reset
        check(1, {5'b0, led, cop_reset_req, cop_nmi_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            do_op(int'(VEC[i][27:24]), VEC[i][23:16], VEC[i][15:8], r);
            if (VEC[i][24]) check(int'(VEC[i][31:28]), r, VEC[i][7:0]);
        end

        // R9 both requests, one cycle wide
        @(negedge clk); host_addr = 8'h33; host_wdata = 8'hC0; host_wr = 1;
        @(negedge clk); host_wr = 0;
        check(9, {6'b0, cop_reset_req, cop_nmi_req}, 8'h03);
        @(negedge clk);
        check(9, {6'b0, cop_reset_req, cop_nmi_req}, 8'h00);
        // R9 NMI only
        @(negedge clk); host_wdata = 8'h40; host_wr = 1;
        @(negedge clk); host_wr = 0;
        check(9, {6'b0, cop_reset_req, cop_nmi_req}, 8'h01);
        // R10 LED set, held over other traffic, then cleared
        do_op(0, 8'h33, 8'h20, r);
        check(10, {7'b0, led}, 8'h01);
        do_op(0, 8'hB3, 8'hFF, r);
        do_op(1, 8'hB3, 8'h00, r);
        check(10, {7'b0, led}, 8'h01);
        do_op(0, 8'h33, 8'h00, r);
        check(10, {7'b0, led}, 8'h00);

        // R11 command set and acknowledge in the same cycle
        @(negedge clk);
        host_addr = 8'hBB; host_wdata = 8'h77; host_wr = 1;
        cop_addr = 8'h05; cop_wr = 1;
        @(negedge clk); host_wr = 0; cop_wr = 0;
        do_op(3, 8'h04, 8'h00, r);
        check(11, r, 8'h01);
        do_op(2, 8'h05, 8'h00, r);
        // R11 host data read against cop reply write
        do_op(1, 8'hB3, 8'h00, r);
        @(negedge clk);
        host_addr = 8'hB3; host_rd = 1;
        cop_addr = 8'h03; cop_wdata = 8'h99; cop_wr = 1;
        @(negedge clk); host_rd = 0; cop_wr = 0;
        do_op(3, 8'h04, 8'h00, r);
        check(11, r, 8'h80);
        // R11 host data write against cop data read
        do_op(3, 8'h02, 8'h00, r);
        @(negedge clk);
        host_addr = 8'hB3; host_wdata = 8'h12; host_wr = 1;
        cop_addr = 8'h02; cop_rd = 1;
        @(negedge clk); host_wr = 0; cop_rd = 0;
        do_op(3, 8'h04, 8'h00, r);
        check(11, r, 8'h80);

        // R1 reset in mid-run clears flags and LED
        do_op(0, 8'hBB, 8'h01, r);
        do_op(0, 8'h33, 8'h20, r);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        check(1, {7'b0, led}, 8'h00);
        do_op(1, 8'hBB, 8'h00, r);
        check(1, r, 8'h7E);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule